// File: doc/BRIEF.md
# Channel Fault Shutdown Retry Controller

This block decides when one output channel of a protected power switch may conduct after a protective shutdown. Software requests the channel on or off through a switch-state write strobe with a value bit. Fault event pulses arrive from the protection circuits: thermal shutdown, overcurrent, and a current-integral trip. A level flag reports load current above a delayed turn-off threshold. The block answers with the channel enable, a latched-off status bit and a switch-state status bit.

Ordinary faults, meaning thermal shutdown and overcurrent, use one of two recovery policies chosen by a latch configuration bit. With auto-retry the channel restarts after a fixed retry interval. With latch-off the channel stays off until software writes the switch state again. Current-integral trips, and a delayed turn-off that fires when the over-threshold flag persists, follow a coded cool-down instead. Code 0 of that cool-down latches the channel off.

All timing counts a tick input with a period of `TICK_US` microseconds, 100 us by default. The retry interval is the parameter `RETRY_TICKS`, 100 ticks (10 ms) by default.

Top module: `chan_retry_ctl`

## Requirements
- R1: After reset, ch_en, latched_off and sw_stat are all 0.
- R2: A strobe with sw_wr_val=1 while the channel is off switches ch_en on at the next clock edge. A strobe with sw_wr_val=0 switches it off at the next edge from any state and cancels a pending retry or cool-down. A strobe of 1 during a retry or cool-down wait neither shortens nor restarts that wait.
- R3: While the channel is on, with latch_cfg=0, a thermal event, or an overcurrent event with i2t_en=0, turns ch_en off at the next edge. ch_en comes back on at the edge that samples the RETRY_TICKS-th tick after the shutdown.
- R4: With latch_cfg=1, the same faults turn the channel off and set latched_off=1. The channel stays off for any number of ticks until a switch-state strobe arrives.
- R5: latched_off rises only on a shutdown of a running channel. A strobe of 0 leaves it at 1. Only a strobe of 1, which turns the channel on, clears it.
- R6: With i2t_en=1, a current-integral trip event shuts the channel down with cool_code policy: 0 latches off (latched_off=1); 1, 2 and 3 restart after 0.8 s, 2.0 s and 4.0 s of ticks (8000, 20000 and 40000 ticks at 100 us).
- R7: With i2t_en=1, when over_thr is high on N consecutive ticks the channel shuts down with the same cool-down policy as R6. N is 2, 4, 10 or 20 for dly_code 0 to 3 (0.2, 0.4, 1.0 and 2.0 ms). A tick sampled with over_thr low restarts the count.
- R8: While i2t_en=1, overcurrent events have no effect on the channel.
- R9: While cap_mode is nonzero and inrush_active=1, current-integral trips and the delayed turn-off are ignored. With cap_mode=0 the inrush flag has no effect.
- R10: sw_stat always equals the real conduction state given by ch_en.
- R11: When a current-integral trip and an ordinary fault occur in the same cycle, the cool-down policy of R6 wins over latch_cfg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Time base pulse, one every TICK_US microseconds |
| sw_wr | input | 1 | Switch-state write strobe |
| sw_wr_val | input | 1 | Value written with the strobe (1 = on) |
| latch_cfg | input | 1 | Ordinary-fault policy: 0 auto-retry, 1 latch off |
| i2t_en | input | 1 | Enables current-integral protection and delayed turn-off |
| cap_mode | input | 2 | Capacitive-charge mode; nonzero means a charge mode is selected |
| inrush_active | input | 1 | Charge period is still running |
| ocp_evt | input | 1 | Overcurrent event pulse |
| tsd_evt | input | 1 | Thermal shutdown event pulse |
| i2t_evt | input | 1 | Current-integral trip event pulse |
| over_thr | input | 1 | Load current above the delayed turn-off threshold |
| cool_code | input | 2 | Cool-down code for integral-class trips |
| dly_code | input | 2 | Delayed turn-off time code |
| ch_en | output | 1 | Channel enable |
| latched_off | output | 1 | Channel is latched off |
| sw_stat | output | 1 | Actual on/off state of the channel |

## Verification
On every cycle, the assertions check the following. A latched channel never conducts. latched_off rises only out of conduction and holds until a strobe of 1. A strobe of 0 always leaves the channel off. Overcurrent events while integral protection is on, and integral trips during a charge period, never stop a running channel. Only the bench scenarios can show the exact retry, cool-down and delayed turn-off durations for each code, the restart of the over-threshold count, the priority between simultaneous faults, and the agreement with a reference model under random fault and tick patterns.

// File: rtl/chan_retry_ctl.sv
module chan_retry_ctl #(
  parameter int TICK_US     = 100,
  parameter int RETRY_TICKS = 10000 / TICK_US
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       sw_wr,
  input  logic       sw_wr_val,
  input  logic       latch_cfg,
  input  logic       i2t_en,
  input  logic [1:0] cap_mode,
  input  logic       inrush_active,
  input  logic       ocp_evt,
  input  logic       tsd_evt,
  input  logic       i2t_evt,
  input  logic       over_thr,
  input  logic [1:0] cool_code,
  input  logic [1:0] dly_code,
  output logic       ch_en,
  output logic       latched_off,
  output logic       sw_stat
);

  localparam int DLY0  = 200 / TICK_US;
  localparam int DLY1  = 400 / TICK_US;
  localparam int DLY2  = 1000 / TICK_US;
  localparam int DLY3  = 2000 / TICK_US;
  localparam int COOL1 = 800000 / TICK_US;
  localparam int COOL2 = 2000000 / TICK_US;
  localparam int COOL3 = 4000000 / TICK_US;
  localparam int MAXW  = (COOL3 > RETRY_TICKS) ? COOL3 : RETRY_TICKS;
  localparam int CW    = $clog2(MAXW + 1);
  localparam int DW    = $clog2(DLY3 + 1);

  typedef enum logic [1:0] {S_OFF, S_ON, S_WAIT} st_t;

  st_t           st;
  logic [CW-1:0] cnt, lim, cool_lim;
  logic [DW-1:0] dly_cnt, dly_lim;
  logic          lat;

  always_comb begin
    case (dly_code)
      2'd0:    dly_lim = DW'(DLY0);
      2'd1:    dly_lim = DW'(DLY1);
      2'd2:    dly_lim = DW'(DLY2);
      default: dly_lim = DW'(DLY3);
    endcase
    case (cool_code)
      2'd1:    cool_lim = CW'(COOL1);
      2'd2:    cool_lim = CW'(COOL2);
      default: cool_lim = CW'(COOL3);
    endcase
  end

  wire on         = (st == S_ON);
  wire chg_block  = (cap_mode != 2'd0) && inrush_active;
  wire integ_ok   = i2t_en && !chg_block;
  wire dly_run    = on && integ_ok && over_thr;
  wire dly_exp    = dly_run && tick && (dly_cnt == dly_lim - DW'(1));
  wire integ_trip = on && integ_ok && (i2t_evt || dly_exp);
  wire norm_trip  = on && (tsd_evt || (ocp_evt && !i2t_en));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_OFF;
      cnt     <= '0;
      lim     <= '0;
      lat     <= 1'b0;
      dly_cnt <= '0;
    end else begin
      if (!dly_run)  dly_cnt <= '0;
      else if (tick) dly_cnt <= dly_exp ? '0 : dly_cnt + DW'(1);

      if (sw_wr && !sw_wr_val) begin
        st <= S_OFF;
      end else if (sw_wr && st == S_OFF) begin
        st  <= S_ON;
        lat <= 1'b0;
      end else begin
        case (st)
          S_ON: begin
            if (integ_trip) begin
              if (cool_code == 2'd0) begin
                st  <= S_OFF;
                lat <= 1'b1;
              end else begin
                st  <= S_WAIT;
                lim <= cool_lim;
                cnt <= '0;
              end
            end else if (norm_trip) begin
              if (latch_cfg) begin
                st  <= S_OFF;
                lat <= 1'b1;
              end else begin
                st  <= S_WAIT;
                lim <= CW'(RETRY_TICKS);
                cnt <= '0;
              end
            end
          end
          S_WAIT: begin
            if (tick) begin
              if (cnt == lim - CW'(1)) st <= S_ON;
              else cnt <= cnt + CW'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ch_en       = on;
  assign sw_stat     = on;
  assign latched_off = lat;

  p_latched_dark_r4: assert property (@(posedge clk) disable iff (!rst_n)
    latched_off |-> !ch_en);

  p_latch_from_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latched_off) |-> $past(ch_en));

  p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    latched_off && !(sw_wr && sw_wr_val) |=> latched_off);

  p_off_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr && !sw_wr_val |=> !ch_en);

  p_ocp_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ch_en && i2t_en && ocp_evt && !tsd_evt && !i2t_evt && !over_thr && !sw_wr |=> ch_en);

  p_charge_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ch_en && cap_mode != 2'd0 && inrush_active && !tsd_evt && !(ocp_evt && !i2t_en) && !sw_wr
      |=> ch_en);

endmodule

// File: tb/test_chan_retry_ctl.sv
module test_chan_retry_ctl;
  localparam int RT = 100;

  logic clk = 0, rst_n = 0, tick = 1, sw_wr = 0, sw_wr_val = 0, latch_cfg = 0, i2t_en = 0;
  logic [1:0] cap_mode = 0, cool_code = 0, dly_code = 0;
  logic inrush_active = 0, ocp_evt = 0, tsd_evt = 0, i2t_evt = 0, over_thr = 0;
  logic ch_en, latched_off, sw_stat;
  int n_chk = 0, n_bad = 0, cyc = 0;

  chan_retry_ctl #(.TICK_US(100), .RETRY_TICKS(RT)) i_chan_retry_ctl (
    .clk, .rst_n, .tick, .sw_wr, .sw_wr_val, .latch_cfg, .i2t_en, .cap_mode,
    .inrush_active, .ocp_evt, .tsd_evt, .i2t_evt, .over_thr, .cool_code,
    .dly_code, .ch_en, .latched_off, .sw_stat);

  always #4 clk = ~clk;

  function automatic int f_dly(input logic [1:0] c);
    case (c) 2'd0: return 2; 2'd1: return 4; 2'd2: return 10; default: return 20; endcase
  endfunction
  function automatic int f_cool(input logic [1:0] c);
    case (c) 2'd0: return 0; 2'd1: return 8000; 2'd2: return 20000; default: return 40000; endcase
  endfunction

  // reference model of the requirements
  int m_st = 0, m_cnt = 0, m_lim = 0, m_dly = 0;
  bit m_lat = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_lim = 0; m_dly = 0; m_lat = 0;
    end else begin
      bit on, iok, run, dexp, itrip, ntrip;
      on    = (m_st == 1);
      iok   = i2t_en && !((cap_mode != 0) && inrush_active);
      run   = on && iok && over_thr;
      dexp  = run && tick && (m_dly == f_dly(dly_code) - 1);
      itrip = on && iok && (i2t_evt || dexp);
      ntrip = on && (tsd_evt || (ocp_evt && !i2t_en));
      if (!run) m_dly = 0; else if (tick) m_dly = dexp ? 0 : m_dly + 1;
      if (sw_wr && !sw_wr_val) m_st = 0;
      else if (sw_wr && m_st == 0) begin m_st = 1; m_lat = 0; end
      else if (m_st == 1) begin
        if (itrip) begin
          if (f_cool(cool_code) == 0) begin m_st = 0; m_lat = 1; end
          else begin m_st = 2; m_lim = f_cool(cool_code); m_cnt = 0; end
        end else if (ntrip) begin
          if (latch_cfg) begin m_st = 0; m_lat = 1; end
          else begin m_st = 2; m_lim = RT; m_cnt = 0; end
        end
      end else if (m_st == 2 && tick) begin
        if (m_cnt == m_lim - 1) m_st = 1; else m_cnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(ch_en == (m_st == 1), "R3 model ch_en", ch_en, m_st == 1);
      chk(latched_off == m_lat, "R5 model latched_off", latched_off, m_lat);
      chk(sw_stat == ch_en, "R10 sw_stat", sw_stat, ch_en);
    end
    if (cyc > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  task automatic step(input int n); repeat (n) @(negedge clk); endtask
  task automatic wr(input bit v);
    sw_wr = 1; sw_wr_val = v; step(1); sw_wr = 0;
  endtask
  task automatic pulse(input bit t, input bit o, input bit i);
    tsd_evt = t; ocp_evt = o; i2t_evt = i; step(1);
    tsd_evt = 0; ocp_evt = 0; i2t_evt = 0;
  endtask

  initial begin
    step(3);
    chk(ch_en == 0 && latched_off == 0 && sw_stat == 0, "R1 reset", ch_en, 0);
    rst_n = 1; step(2);
    chk(ch_en == 0, "R1 after release", ch_en, 0);

    wr(1);
    chk(ch_en == 1, "R2 write on", ch_en, 1);
    chk(sw_stat == 1, "R10 sw_stat on", sw_stat, 1);

    // R3 auto retry
    pulse(1, 0, 0);
    chk(ch_en == 0, "R3 shutdown", ch_en, 0);
    step(RT - 1);
    chk(ch_en == 0, "R3 before retry", ch_en, 0);
    step(1);
    chk(ch_en == 1, "R3 retry", ch_en, 1);

    // R4 / R5 latch off
    latch_cfg = 1;
    pulse(0, 1, 0);
    chk(ch_en == 0 && latched_off == 1, "R4 latch", latched_off, 1);
    step(300);
    chk(ch_en == 0, "R4 stays off", ch_en, 0);
    wr(0);
    chk(latched_off == 1, "R5 zero keeps latch", latched_off, 1);
    wr(1);
    chk(ch_en == 1 && latched_off == 0, "R5 toggle clears", latched_off, 0);

    // R8 overcurrent ignored in integral mode
    i2t_en = 1;
    pulse(0, 1, 0); step(2);
    chk(ch_en == 1, "R8 ocp ignored", ch_en, 1);

    // R9 charge period blocks integral trip
    cap_mode = 2'd1; inrush_active = 1;
    pulse(0, 0, 1); step(2);
    chk(ch_en == 1, "R9 blocked in charge", ch_en, 1);
    cap_mode = 2'd0;
    pulse(0, 0, 1);
    chk(ch_en == 0 && latched_off == 1, "R9 no mode no block / R6 code0 latch", latched_off, 1);
    inrush_active = 0;
    wr(1);

    // R6 cool-down code 1 with a write of 1 in the middle
    cool_code = 2'd1;
    pulse(0, 0, 1);
    step(4000); wr(1); step(8000 - 4000 - 2);
    chk(ch_en == 0, "R6 code1 before end", ch_en, 0);
    step(1);
    chk(ch_en == 1, "R6 code1 restart / R2 write ignored", ch_en, 1);

    // R6 code 3
    cool_code = 2'd3;
    pulse(0, 0, 1);
    step(40000 - 1);
    chk(ch_en == 0, "R6 code3 before end", ch_en, 0);
    step(1);
    chk(ch_en == 1, "R6 code3 restart", ch_en, 1);

    // R2 cancel during code 2 wait
    cool_code = 2'd2;
    pulse(0, 0, 1);
    step(100); wr(0); step(20100);
    chk(ch_en == 0, "R2 cancel pending", ch_en, 0);
    wr(1);

    // R11 priority
    latch_cfg = 1; cool_code = 2'd1;
    pulse(1, 0, 1);
    chk(ch_en == 0 && latched_off == 0, "R11 integral wins", latched_off, 0);
    step(8000);
    chk(ch_en == 1, "R11 restart", ch_en, 1);

    // R7 delayed turn-off
    cool_code = 2'd0; dly_code = 2'd2;
    over_thr = 1; step(9); over_thr = 0; step(1); over_thr = 1; step(9);
    chk(ch_en == 1, "R7 count restarts", ch_en, 1);
    step(1);
    chk(ch_en == 0 && latched_off == 1, "R7 expiry", ch_en, 0);
    over_thr = 0; wr(1);

    // random phase against the model
    void'($urandom(32'h5eed));
    latch_cfg = 0; i2t_en = 0;
    for (int k = 0; k < 20000; k++) begin
      tick      = ($urandom % 10) != 0;
      sw_wr     = ($urandom % 300) == 0;
      sw_wr_val = ($urandom % 4) != 0;
      tsd_evt   = ($urandom % 400) == 0;
      ocp_evt   = ($urandom % 400) == 0;
      i2t_evt   = ($urandom % 500) == 0;
      over_thr  = ($urandom % 8) != 0;
      if (($urandom % 500) == 0) begin
        latch_cfg = $urandom; i2t_en = $urandom; dly_code = $urandom;
        cool_code = $urandom % 2; cap_mode = $urandom; inrush_active = $urandom;
      end
      step(1);
    end
    tick = 1; sw_wr = 0; tsd_evt = 0; ocp_evt = 0; i2t_evt = 0; over_thr = 0;
    step(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule